// File: doc/BRIEF.md
# Morse Letter Encoder

This block turns a three-bit letter code into a Morse pattern played on one light output. The code covers the eight letters A to H. When a start pulse arrives and the block is idle, it takes the selected letter's pattern and symbol count from an internal table. It then plays the symbols one after another as high pulses, with a low gap between them.

All timing is counted in units. One unit is one half-second tick, taken from an internal divider whose length in clock cycles is a parameter. A simulation can therefore shrink the divider to a few cycles. The busy flag stays high for the whole playback. A start pulse seen while busy is dropped, and the letter select is only read at the moment a start is accepted.

Top module: `morse_letter_tx`

## Requirements
- R1: The letter select maps code 0 to A, 1 to B and so on up to 7 for H. The symbols played, first to last, are: A dot dash; B dash dot dot dot; C dash dot dash dot; D dash dot dot; E dot; F dot dot dash dot; G dash dash dot; H dot dot dot dot.
- R2: A dot holds the light high for DOT_UNITS ticks (default 1), which is DOT_UNITS*TICK_DIV clock cycles.
- R3: A dash holds the light high for DASH_UNITS ticks (default 3), which is DASH_UNITS*TICK_DIV clock cycles.
- R4: Between two symbols of one letter, the light is low for GAP_UNITS ticks (default 1) while busy stays high.
- R5: Busy is high whenever the light is high. Light and busy go low together in the same cycle when the last symbol ends.
- R6: A start pulse while busy is ignored, and so is any change of the letter select during playback. The pattern in progress runs to its end unchanged.
- R7: An active-low reset is asynchronous. It forces the light and busy low at once and returns the block to idle.
- R8: While idle, the light is low. A start sampled on a clock edge while idle makes the light and busy high from that edge on, and the divider restarts so that the first symbol is full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled on the rising clock edge |
| letter | input | 3 | Letter select, 0 = A to 7 = H |
| light | output | 1 | Morse output, high during a dot or dash |
| busy | output | 1 | High while a letter is being played |

## Verification
Each of the eight letters is first played once by itself. Comparing its high runs with one another separates dots from dashes, and counting them checks the table and the left-to-right order. Random plays follow, some back to back and some after idle cycles. Some of them carry a second start and a changed letter select in the middle of playback, so a pattern that restarts or reloads shows up as a wrong run count or wrong run lengths. A reset raised in the middle of a cycle, part way through a letter, must clear the outputs with no clock edge. A letter played after it must then come out complete.

// File: rtl/morse_pkg.sv
package morse_pkg;

   localparam int SEL_W = 3;
   localparam int PAT_W = 4;
   localparam int LEN_W = 3;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_MARK  = 2'd1,
      ST_SPACE = 2'd2
   } tx_state_e;

   typedef enum logic [1:0] {
      U_DOT  = 2'd0,
      U_DASH = 2'd1,
      U_GAP  = 2'd2
   } unit_kind_e;

   // bits: left aligned, 1 = dash, MSB played first
   typedef struct packed {
      logic [LEN_W-1:0] len;
      logic [PAT_W-1:0] bits;
   } glyph_t;

   function automatic glyph_t glyph_of(input logic [SEL_W-1:0] sel);
      glyph_t g;
      case (sel)
         3'd0:    g = '{len: 3'd2, bits: 4'b0100};
         3'd1:    g = '{len: 3'd4, bits: 4'b1000};
         3'd2:    g = '{len: 3'd4, bits: 4'b1010};
         3'd3:    g = '{len: 3'd3, bits: 4'b1000};
         3'd4:    g = '{len: 3'd1, bits: 4'b0000};
         3'd5:    g = '{len: 3'd4, bits: 4'b0010};
         3'd6:    g = '{len: 3'd3, bits: 4'b1100};
         default: g = '{len: 3'd4, bits: 4'b0000};
      endcase
      return g;
   endfunction

endpackage

// File: rtl/morse_glyph_rom.sv
module morse_glyph_rom
   import morse_pkg::*;
(
   input  logic [SEL_W-1:0] sel,
   output glyph_t           glyph
);
   always_comb glyph = glyph_of(sel);
endmodule

// File: rtl/morse_tick_gen.sv
module morse_tick_gen #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt;

   // Held at zero while idle so every playback starts on a fresh unit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!run)        cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt == LAST);
endmodule

// File: rtl/morse_symbol_reg.sv
module morse_symbol_reg
   import morse_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   load,
   input  logic   shift,
   input  glyph_t glyph_in,
   output logic   head_dash,
   output logic   last
);
   logic [PAT_W-1:0] pat;
   logic [LEN_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pat  <= '0;
         left <= '0;
      end else if (load) begin
         pat  <= glyph_in.bits;
         left <= glyph_in.len;
      end else if (shift) begin
         pat  <= {pat[PAT_W-2:0], 1'b0};
         left <= left - 1'b1;
      end
   end

   assign head_dash = pat[PAT_W-1];
   assign last      = (left == LEN_W'(1));
endmodule

// File: rtl/morse_unit_timer.sv
module morse_unit_timer
   import morse_pkg::*;
#(
   parameter int DOT_UNITS  = 1,
   parameter int DASH_UNITS = 3,
   parameter int GAP_UNITS  = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  unit_kind_e kind,
   input  logic       tick,
   output logic       expire
);
   localparam int MAXU = (DASH_UNITS > GAP_UNITS) ? DASH_UNITS : GAP_UNITS;
   localparam int UW   = $clog2(MAXU + 1);

   logic [UW-1:0] cnt;
   logic [UW-1:0] reload;

   always_comb begin
      case (kind)
         U_DASH:  reload = UW'(DASH_UNITS);
         U_GAP:   reload = UW'(GAP_UNITS);
         default: reload = UW'(DOT_UNITS);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (load)  cnt <= reload;
      else if (tick)  cnt <= cnt - 1'b1;
   end

   assign expire = tick && (cnt == UW'(1));
endmodule

// File: rtl/morse_ctrl.sv
module morse_ctrl
   import morse_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       rom_head_dash,
   input  logic       reg_head_dash,
   input  logic       last,
   input  logic       expire,
   output logic       ld_glyph,
   output logic       shift,
   output logic       ld_units,
   output unit_kind_e kind,
   output logic       light,
   output logic       busy
);
   tx_state_e state, nxt;

   always_comb begin
      nxt      = state;
      ld_glyph = 1'b0;
      shift    = 1'b0;
      ld_units = 1'b0;
      kind     = U_DOT;
      case (state)
         ST_IDLE: if (start) begin
            ld_glyph = 1'b1;
            ld_units = 1'b1;
            kind     = rom_head_dash ? U_DASH : U_DOT;
            nxt      = ST_MARK;
         end
         ST_MARK: if (expire) begin
            if (last) begin
               nxt = ST_IDLE;
            end else begin
               shift    = 1'b1;
               ld_units = 1'b1;
               kind     = U_GAP;
               nxt      = ST_SPACE;
            end
         end
         ST_SPACE: if (expire) begin
            ld_units = 1'b1;
            kind     = reg_head_dash ? U_DASH : U_DOT;
            nxt      = ST_MARK;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   assign light = (state == ST_MARK);
   assign busy  = (state != ST_IDLE);
endmodule

// File: rtl/morse_letter_tx.sv
module morse_letter_tx
   import morse_pkg::*;
#(
   parameter int TICK_DIV   = 25_000_000,
   parameter int DOT_UNITS  = 1,
   parameter int DASH_UNITS = 3,
   parameter int GAP_UNITS  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [SEL_W-1:0] letter,
   output logic             light,
   output logic             busy
);
   generate
      if (TICK_DIV < 2) begin : g_bad_div
         $error("TICK_DIV must be at least 2");
      end
      if (DOT_UNITS < 1 || GAP_UNITS < 1) begin : g_bad_unit
         $error("DOT_UNITS and GAP_UNITS must be at least 1");
      end
      if (DASH_UNITS <= DOT_UNITS) begin : g_bad_dash
         $error("DASH_UNITS must exceed DOT_UNITS");
      end
   endgenerate

   glyph_t     rom_glyph;
   logic       tick, expire, last, reg_head;
   logic       ld_glyph, shift, ld_units;
   unit_kind_e kind;

   morse_glyph_rom u_rom (
      .sel   (letter),
      .glyph (rom_glyph)
   );

   morse_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .tick  (tick)
   );

   morse_symbol_reg u_sym (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ld_glyph),
      .shift     (shift),
      .glyph_in  (rom_glyph),
      .head_dash (reg_head),
      .last      (last)
   );

   morse_unit_timer #(
      .DOT_UNITS  (DOT_UNITS),
      .DASH_UNITS (DASH_UNITS),
      .GAP_UNITS  (GAP_UNITS)
   ) u_units (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (ld_units),
      .kind   (kind),
      .tick   (tick),
      .expire (expire)
   );

   morse_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .rom_head_dash (rom_glyph.bits[PAT_W-1]),
      .reg_head_dash (reg_head),
      .last          (last),
      .expire        (expire),
      .ld_glyph      (ld_glyph),
      .shift         (shift),
      .ld_units      (ld_units),
      .kind          (kind),
      .light         (light),
      .busy          (busy)
   );
endmodule

// File: rtl/morse_letter_tx_chk.sv
module morse_letter_tx_chk #(
   parameter int TICK_DIV   = 4,
   parameter int DOT_UNITS  = 1,
   parameter int DASH_UNITS = 3,
   parameter int GAP_UNITS  = 1
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic light,
   input logic busy
);
   int hi_cnt, lo_cnt;

   // Run-length counters: cycles high, and cycles low while busy
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= 0;
         lo_cnt <= 0;
      end else begin
         hi_cnt <= light ? hi_cnt + 1 : 0;
         lo_cnt <= (busy && !light) ? lo_cnt + 1 : 0;
      end
   end

   a_r5_light_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      light |-> busy) else $error("light without busy");

   a_r8_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && light)) else $error("start not taken");

   a_r2_r3_mark_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(light) |-> (hi_cnt == DOT_UNITS*TICK_DIV || hi_cnt == DASH_UNITS*TICK_DIV))
      else $error("mark length wrong");

   a_r4_gap_length: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(light) && $past(busy)) |-> (lo_cnt == GAP_UNITS*TICK_DIV))
      else $error("gap length wrong");

   always @(posedge clk) begin
      if (!rst_n) begin
         a_r7_reset_idle: assert (!light && !busy) else $error("outputs high in reset");
      end
   end
endmodule

bind morse_letter_tx morse_letter_tx_chk #(
   .TICK_DIV   (TICK_DIV),
   .DOT_UNITS  (DOT_UNITS),
   .DASH_UNITS (DASH_UNITS),
   .GAP_UNITS  (GAP_UNITS)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .light (light),
   .busy  (busy)
);

// File: tb/morse_letter_tx_test.sv
module morse_letter_tx_test;
   localparam int CLK_NS = 10;
   localparam int DIV    = 3;

   logic       clk = 1'b0;
   logic       rst_n, start;
   logic [2:0] letter;
   logic       light, busy;
   int         n_cmp = 0, n_bad = 0;

   always #(CLK_NS/2) clk = ~clk;

   morse_letter_tx #(.TICK_DIV(DIV)) uut (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .letter (letter),
      .light  (light),
      .busy   (busy)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // R1: expected symbols per letter code
   function automatic string code_of(input int l);
      case (l)
         0: return ".-";
         1: return "-...";
         2: return "-.-.";
         3: return "-..";
         4: return ".";
         5: return "..-.";
         6: return "--.";
         default: return "....";
      endcase
   endfunction

   function automatic int sym_cycles(input byte c);
      return (c == "-") ? 3*DIV : DIV;
   endfunction

   task automatic play(input int ltr, input bit poke);
      string code = code_of(ltr);
      int    n    = code.len();
      int    runs[16];
      int    nr = 0, cur = 1, cyc = 0, tot = 0, p = -1;
      bit    curv = 1'b1;
      for (int k = 0; k < n; k++) tot += sym_cycles(code[k]);
      tot += DIV*(n-1);
      if (poke) p = int'($urandom_range(tot-2, 1));
      letter = 3'(ltr);
      start  = 1'b1;
      @(negedge clk);
      start  = 1'b0;
      letter = 3'($urandom);   // R6: select changes during playback
      check(busy && light, "R8 start raises outputs", int'({busy, light}), 3);
      forever begin
         @(negedge clk);
         cyc++;
         start = (cyc == p);   // R6: start while busy
         if (!busy) begin
            start = 1'b0;
            check(!light, "R5 light low at end", int'(light), 0);
            check(curv, "R5 last run is a mark", int'(curv), 1);
            if (nr < 15) runs[nr++] = cur;
            break;
         end
         if (cyc > 2000) break;
         if (light == curv) cur++;
         else begin
            if (nr < 15) runs[nr++] = cur;
            curv = light;
            cur  = 1;
         end
      end
      check(nr == 2*n-1, "R1 R6 run count", nr, 2*n-1);
      for (int i = 0; i < nr && i < 2*n-1; i++) begin
         if (i % 2 == 1)
            check(runs[i] == DIV, "R4 gap length", runs[i], DIV);
         else if (code[i/2] == "-")
            check(runs[i] == 3*DIV, "R1 R3 dash length", runs[i], 3*DIV);
         else
            check(runs[i] == DIV, "R1 R2 dot length", runs[i], DIV);
      end
   endtask

   initial begin
      #(CLK_NS*150000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n  = 1'b0;
      start  = 1'b0;
      letter = 3'd0;
      repeat (3) @(negedge clk);
      check(!light && !busy, "R7 reset state", int'({busy, light}), 0);
      rst_n = 1'b1;
      repeat (4) begin
         @(negedge clk);
         check(!light && !busy, "R8 idle low", int'({busy, light}), 0);
      end
      for (int l = 0; l < 8; l++) play(l, 1'b0);
      for (int it = 0; it < 24; it++) begin
         repeat ($urandom % 4) @(negedge clk);
         play(int'($urandom % 8), 1'(($urandom % 2)));
      end
      // R7: asynchronous reset in the middle of a letter
      letter = 3'd1;
      start  = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(!light && !busy, "R7 async clear", int'({busy, light}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      play(7, 1'b0);
      play(6, 1'b1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule